// File: doc/BRIEF.md
# Programmable Bit-Permutation Crossbar

This block moves the bits of a 32-bit word to any set of output positions. It keeps a routing table of 32 rows of 32 bits, one row per input bit. A 1 in column j of row i connects input bit i to output bit j. The block ANDs each input bit with its row, then ORs each column. So one input bit can drive several outputs, several inputs can merge into one output, and an output with an empty column stays at 0.

Software loads the table one row per cycle through an indexed write port. It then pulses the apply strobe with a data word. The mapped word is registered and appears on the result output at the clock edge that takes the strobe. The result holds that value until the next apply.

Top module: `bit_permute_xbar`

## Requirements
- R1: Reset clears every table row and the result register, so the result reads 0 after reset and any apply reads 0 until a row is written.
- R2: When apply is high at a rising edge, the result after that edge has bit j equal to the OR, over all i, of (data bit i AND bit j of row i).
- R3: One input bit whose row holds several 1s sets every one of those output bits.
- R4: Input bits whose rows share a 1 in the same column are OR-combined into that output bit.
- R5: An output bit whose column is 0 in every row reads 0 for any input word.
- R6: A write stores the value in the row chosen by the index (0 to 31) and leaves the other 31 rows unchanged.
- R7: A write and an apply in the same cycle map the data through the table as it was before that write.
- R8: The result holds its value in every cycle without an apply, including cycles with table writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr_en | input | 1 | Write one table row this cycle |
| tbl_wr_idx | input | 5 | Row (input bit) number to write |
| tbl_wr_row | input | 32 | Row value; bit j routes that input bit to output j |
| apply_en | input | 1 | Map apply_data through the table this cycle |
| apply_data | input | 32 | Word to be mapped |
| result | output | 32 | Registered mapped word from the last apply |

## Verification
The bench goes after the following corner cases and the wrong behaviour each would expose:
- **Fan-out:** a row with many 1s driven by a single bit. A decoder-style design that honoured only one 1 per row would drop outputs.
- **Merging:** several rows sharing one column. An implementation that let the highest-numbered row win, instead of ORing, would clear the bit when that row's input is 0.
- **Empty columns:** random tables with masked columns, applied with all-ones data. These expose any leakage into bits that must stay 0.
- **Write-plus-apply in one cycle:** this exposes a write-through path that maps the data with the new row.
- **Row isolation and hold:** probing neighbouring rows catches a mis-decoded write index, and writes between applies catch a result that moves without an apply.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  localparam int XB_DEF_W = 32;

  // number of index bits needed to address w rows
  function automatic int xb_idx_bits(input int w);
    return (w <= 2) ? 1 : $clog2(w);
  endfunction

endpackage

// File: rtl/xbar_route_table.sv
module xbar_route_table #(
  parameter int W  = xbar_pkg::XB_DEF_W,
  parameter int IW = xbar_pkg::xb_idx_bits(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [W-1:0]    wr_row,
  output logic [W*W-1:0]  rows_flat
);

  localparam int CELLS = W * W;

  logic [CELLS-1:0] mem;
  logic [W-1:0]     wr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (wr_en) begin
      mem[wr_idx*W +: W] <= wr_row;
    end
  end

  assign rows_flat = mem;

  // the written row holds the written value afterwards
  assert_row_written_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_idx)*W +: W] == $past(wr_row));

  for (genvar gi = 0; gi < W; gi++) begin : g_row
    assign wr_hit[gi] = wr_en && (wr_idx == IW'(gi));

    // rows not addressed are untouched
    assert_row_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[gi] |=> $stable(mem[gi*W +: W]));
  end

  assert_one_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

endmodule

// File: rtl/xbar_and_or.sv
module xbar_and_or #(
  parameter int W = xbar_pkg::XB_DEF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W*W-1:0]  rows_flat,
  input  logic [W-1:0]    din,
  output logic [W-1:0]    mapped,
  output logic [W-1:0]    col_any
);

  // column j of the table: bit i is row i, bit j
  function automatic logic [W-1:0] column_of(input logic [W*W-1:0] t, input int j);
    logic [W-1:0] c;
    for (int i = 0; i < W; i++) c[i] = t[i*W + j];
    return c;
  endfunction

  for (genvar gj = 0; gj < W; gj++) begin : g_col
    logic [W-1:0] col;
    assign col         = column_of(rows_flat, gj);
    assign mapped[gj]  = |(col & din);
    assign col_any[gj] = |col;
  end

  // an empty column never produces a 1
  assert_empty_col_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mapped & ~col_any) == '0);

  // with all inputs zero nothing is driven
  assert_zero_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (din == '0) |-> (mapped == '0));

endmodule

// File: rtl/xbar_result_reg.sv
module xbar_result_reg #(
  parameter int W = xbar_pkg::XB_DEF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  nxt,
  output logic [W-1:0]  q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= nxt;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> q == '0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && rst_n) |=> $stable(q));

endmodule

// File: rtl/bit_permute_xbar.sv
module bit_permute_xbar #(
  parameter  int W  = xbar_pkg::XB_DEF_W,
  localparam int IW = xbar_pkg::xb_idx_bits(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tbl_wr_en,
  input  logic [IW-1:0]  tbl_wr_idx,
  input  logic [W-1:0]   tbl_wr_row,
  input  logic           apply_en,
  input  logic [W-1:0]   apply_data,
  output logic [W-1:0]   result
);

  logic [W*W-1:0] rows_flat;
  logic [W-1:0]   mapped;
  logic [W-1:0]   col_any;

  xbar_route_table #(.W(W), .IW(IW)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_wr_en),
    .wr_idx    (tbl_wr_idx),
    .wr_row    (tbl_wr_row),
    .rows_flat (rows_flat)
  );

  xbar_and_or #(.W(W)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .rows_flat (rows_flat),
    .din       (apply_data),
    .mapped    (mapped),
    .col_any   (col_any)
  );

  xbar_result_reg #(.W(W)) u_res (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (apply_en),
    .nxt   (mapped),
    .q     (result)
  );

  // apply captures the mapping of the table as it stood before this edge
  assert_apply_old_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_en && rst_n) |=> result == $past(mapped));

  // a result bit can only be 1 if its column had some 1 at apply time
  assert_result_in_cols_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_en && rst_n) |=> (result & ~$past(col_any)) == '0);

endmodule

// File: tb/sim_bit_permute_xbar.sv
module sim_bit_permute_xbar;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_wr_en = 1'b0;
  logic [4:0]  tbl_wr_idx = '0;
  logic [31:0] tbl_wr_row = '0;
  logic        apply_en = 1'b0;
  logic [31:0] apply_data = '0;
  logic [31:0] result;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] mdl [32];
  logic [31:0] exp_res;

  always #10 clk = ~clk;

  bit_permute_xbar u0 (
    .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
    .tbl_wr_row(tbl_wr_row), .apply_en(apply_en), .apply_data(apply_data),
    .result(result)
  );

  // row-wise model: OR together the rows of every set input bit
  function automatic logic [31:0] model_map(input logic [31:0] d);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) if (d[i]) r = r | mdl[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: result=%08h expected=%08h", req, got, exp);
    end
  endtask

  // called just after a negedge; returns just after the following negedge
  task automatic step(input logic we, input logic [4:0] idx, input logic [31:0] w,
                      input logic ap, input logic [31:0] d);
    tbl_wr_en = we; tbl_wr_idx = idx; tbl_wr_row = w;
    apply_en = ap; apply_data = d;
    @(posedge clk); #1;
    if (ap) exp_res = model_map(d);
    if (we) mdl[idx] = w;
    @(negedge clk);
    tbl_wr_en = 1'b0; apply_en = 1'b0;
  endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] w);
    step(1'b1, idx, w, 1'b0, '0);
  endtask

  task automatic ap(input logic [31:0] d);
    step(1'b0, '0, '0, 1'b1, d);
  endtask

  task automatic clear_tbl();
    for (int i = 0; i < 32; i++) wr(5'(i), '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: result=%08h expected=completion", result);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20241));
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    exp_res = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", result, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", result, 32'h0);
    ap(32'hFFFF_FFFF);
    check("R1 cleared table", result, 32'h0);

    // identity
    for (int i = 0; i < 32; i++) wr(5'(i), 32'h1 << i);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] d = $urandom;
      ap(d);
      check("R2 identity", result, d);
    end
    // reversal
    for (int i = 0; i < 32; i++) wr(5'(i), 32'h1 << (31 - i));
    for (int k = 0; k < 4; k++) begin
      logic [31:0] d = $urandom;
      logic [31:0] rv;
      for (int b = 0; b < 32; b++) rv[b] = d[31-b];
      ap(d);
      check("R2 reversal", result, rv);
    end

    // fan-out
    clear_tbl();
    wr(5'd3, 32'hF0F0_0001);
    ap(32'h0000_0008);
    check("R3 fan-out", result, 32'hF0F0_0001);
    ap(32'hFFFF_FFF7);
    check("R3 other bits idle", result, 32'h0);

    // merge
    for (int i = 0; i < 4; i++) wr(5'(i), 32'h80);
    for (int i = 0; i < 4; i++) begin
      ap(32'h1 << i);
      check("R4 merge single", result, 32'h80);
    end
    ap(32'h0000_000F);
    check("R4 merge all", result, 32'h80);
    ap(32'h0000_0000);
    check("R4 merge none", result, 32'h0);

    // forced zero columns
    for (int k = 0; k < 3; k++) begin
      logic [31:0] mask = $urandom;
      for (int i = 0; i < 32; i++) wr(5'(i), $urandom & ~mask);
      ap(32'hFFFF_FFFF);
      check("R5 empty columns", result & mask, 32'h0);
      check("R5 full map", result, exp_res);
    end

    // row isolation
    clear_tbl();
    wr(5'd9, 32'hA5A5_5A5A);
    ap(32'h1 << 9);
    check("R6 written row", result, 32'hA5A5_5A5A);
    ap(32'h1 << 8);
    check("R6 row below", result, 32'h0);
    ap(32'h1 << 10);
    check("R6 row above", result, 32'h0);
    wr(5'd31, 32'h8000_0001);
    ap(32'h8000_0000);
    check("R6 top row", result, 32'h8000_0001);

    // write and apply together
    step(1'b1, 5'd9, 32'h0000_FFFF, 1'b1, 32'h1 << 9);
    check("R7 old table", result, 32'hA5A5_5A5A);
    ap(32'h1 << 9);
    check("R7 new table next", result, 32'h0000_FFFF);

    // hold
    wr(5'd9, 32'h1234_5678);
    wr(5'd0, 32'hFFFF_FFFF);
    check("R8 hold over writes", result, 32'h0000_FFFF);
    repeat (3) @(negedge clk);
    check("R8 hold idle", result, 32'h0000_FFFF);

    // random mix
    for (int k = 0; k < 300; k++) begin
      logic we = $urandom_range(0, 1);
      logic a  = $urandom_range(0, 1);
      step(we, 5'($urandom_range(0, 31)), $urandom, a, $urandom);
      check(a ? "R2 random apply" : "R8 random hold", result, exp_res);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule